// File: doc/BRIEF.md
# FIR Multiply-Accumulate Engine

This block computes a single output of an N-tap finite impulse response filter. The output is the sum over every tap i of coefficient a[i] times sample x[j-i], where x[j] is the most recent sample. One signed multiply-accumulate datapath does the work. Two address walkers feed it. The coefficient walker counts upward through an internal coefficient bank. The sample walker counts downward, wrapping modulo N, through an internal ring that holds the N most recent samples. New samples overwrite the oldest slot, so the window slides forward without moving any data.

Samples arrive on a valid/ready stream. Coefficients are loaded through a simple write port. A start pulse launches one evaluation, which uses one MAC step per tap. The operand fetch for the next tap overlaps the current MAC. When the evaluation ends, a one-cycle done pulse marks the full-width result as final. Both storage arrays are frozen while an evaluation is in progress.

Top module: `fir_mac_engine`

## Requirements
- R1: After synchronous reset, result is 0, done and busy are low, samp_ready is high, and every coefficient and ring slot reads as 0.
- R2: A finished evaluation yields result = sum over i in 0..N-1 of a[i]*x[j-i]. All values are signed two's complement. x[j] is the most recently accepted sample, and ring slots never written count as 0.
- R3: Each accepted sample replaces the oldest of the N stored samples, so the window always holds exactly the N newest samples.
- R4: A start accepted while idle raises busy on the next cycle. done is then high for exactly one cycle, N cycles after the start edge, and busy falls in that same cycle.
- R5: An accepted start clears the accumulator. After done, result holds its value until the next accepted start.
- R6: A start raised while busy is ignored. It neither restarts the evaluation nor produces an extra done.
- R7: samp_ready is low while busy or while start is high. A sample offered then is not stored and does not affect any later result.
- R8: When idle and start is low, coef_we writes coef_data to coefficient coef_addr. A coefficient write attempted while busy is discarded.
- R9: The accumulator is 2*DW + ceil(log2 N) bits wide, so N products of the most negative values are summed exactly.
- R10: On every MAC step the coefficient address advances by one modulo N, and the sample address steps back by one modulo N, wrapping from 0 to N-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | AW | Tap index to write |
| coef_data | input | DW | Signed coefficient value |
| samp_valid | input | 1 | Sample offered |
| samp_data | input | DW | Signed sample value |
| samp_ready | output | 1 | Ring can accept a sample this cycle |
| start | input | 1 | Launch one evaluation |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-cycle pulse: result is final |
| result | output | ACCW | Signed accumulated sum |

## Verification
A walker that wraps or steps in the wrong direction pairs a coefficient with the wrong sample. The error shows in result at the first done after a window that holds distinct values. A ring write pointer that slips, or a write that gets through while busy, shows the same way at the next evaluation. A step counter that is off by one moves done a cycle early or late. It also drops a tap or adds one, and both effects are visible at that same done. A stuck busy flag shows as a missing done within N+1 cycles of start.

// File: rtl/fir_mac_pkg.sv
package fir_mac_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    function automatic int wrap_up(input int v, input int n);
        return (v >= n - 1) ? 0 : v + 1;
    endfunction

    function automatic int wrap_down(input int v, input int n);
        return (v <= 0) ? n - 1 : v - 1;
    endfunction

    function automatic int addr_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/fir_addr_gen.sv
module fir_addr_gen
    import fir_mac_pkg::*;
#(
    parameter int N    = 8,
    parameter bit DOWN = 1'b0,
    localparam int AW  = addr_bits(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] init,
    output logic [AW-1:0] cur
);
    logic [AW-1:0] ptr;
    logic [AW-1:0] nxt;

    assign cur = load ? init : ptr;

    generate
        if (DOWN) begin : g_down
            assign nxt = AW'(wrap_down(int'(cur), N));
        end else begin : g_up
            assign nxt = AW'(wrap_up(int'(cur), N));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (load || step)
            ptr <= nxt;
    end

    // R10
    walk_step_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> (DOWN ? (ptr == (($past(ptr) == 0) ? AW'(N-1) : $past(ptr) - 1'b1))
                                  : (ptr == (($past(ptr) == AW'(N-1)) ? '0 : $past(ptr) + 1'b1))));

endmodule

// File: rtl/fir_coef_bank.sv
module fir_coef_bank
    import fir_mac_pkg::*;
#(
    parameter int N   = 8,
    parameter int DW  = 16,
    localparam int AW = addr_bits(N)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [AW-1:0]        waddr,
    input  logic signed [DW-1:0] wdata,
    input  logic [AW-1:0]        raddr,
    output logic signed [DW-1:0] rdata
);
    logic signed [DW-1:0] taps [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) taps[i] <= '0;
        end else if (we && (int'(waddr) < N)) begin
            taps[waddr] <= wdata;
        end
    end

    assign rdata = (int'(raddr) < N) ? taps[raddr] : '0;

endmodule

// File: rtl/fir_sample_ring.sv
module fir_sample_ring
    import fir_mac_pkg::*;
#(
    parameter int N   = 8,
    parameter int DW  = 16,
    localparam int AW = addr_bits(N)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic signed [DW-1:0] wr_data,
    input  logic [AW-1:0]        rd_addr,
    output logic signed [DW-1:0] rd_data,
    output logic [AW-1:0]        newest
);
    logic signed [DW-1:0] slot [N];
    logic [AW-1:0]        oldest;

    always_ff @(posedge clk) begin
        if (rst) begin
            oldest <= '0;
            for (int i = 0; i < N; i++) slot[i] <= '0;
        end else if (wr_en) begin
            slot[oldest] <= wr_data;
            oldest       <= AW'(wrap_up(int'(oldest), N));
        end
    end

    assign newest  = AW'(wrap_down(int'(oldest), N));
    assign rd_data = (int'(rd_addr) < N) ? slot[rd_addr] : '0;

    // R3
    ring_adv_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (newest == $past(oldest)));

endmodule

// File: rtl/fir_mac_acc.sv
module fir_mac_acc #(
    parameter int DW   = 16,
    parameter int ACCW = 35
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clr,
    input  logic                   en,
    input  logic signed [DW-1:0]   mx,
    input  logic signed [DW-1:0]   my,
    output logic signed [ACCW-1:0] acc
);
    logic signed [2*DW-1:0] prod;

    assign prod = mx * my;

    always_ff @(posedge clk) begin
        if (rst || clr)
            acc <= '0;
        else if (en)
            acc <= acc + ACCW'(prod);
    end

    // R5
    acc_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (acc == '0));

endmodule

// File: rtl/fir_mac_engine.sv
module fir_mac_engine
    import fir_mac_pkg::*;
#(
    parameter int N     = 8,
    parameter int DW    = 16,
    localparam int AW   = addr_bits(N),
    localparam int ACCW = 2*DW + addr_bits(N)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   coef_we,
    input  logic [AW-1:0]          coef_addr,
    input  logic signed [DW-1:0]   coef_data,
    input  logic                   samp_valid,
    input  logic signed [DW-1:0]   samp_data,
    output logic                   samp_ready,
    input  logic                   start,
    output logic                   busy,
    output logic                   done,
    output logic signed [ACCW-1:0] result
);
    run_state_e           state;
    logic [AW-1:0]        steps_left;
    logic                 go, step, open;
    logic [AW-1:0]        c_addr, s_addr, newest;
    logic signed [DW-1:0] c_rd, s_rd;
    logic signed [DW-1:0] mx, my;

    assign go         = start && (state == ST_IDLE);
    assign step       = (state == ST_RUN);
    assign open       = (state == ST_IDLE) && !start;
    assign samp_ready = open;
    assign busy       = (state == ST_RUN);

    fir_coef_bank #(.N(N), .DW(DW)) i_coef (
        .clk(clk), .rst(rst), .we(coef_we && open), .waddr(coef_addr),
        .wdata(coef_data), .raddr(c_addr), .rdata(c_rd));

    fir_sample_ring #(.N(N), .DW(DW)) i_ring (
        .clk(clk), .rst(rst), .wr_en(samp_valid && open), .wr_data(samp_data),
        .rd_addr(s_addr), .rd_data(s_rd), .newest(newest));

    fir_addr_gen #(.N(N), .DOWN(1'b0)) i_cwalk (
        .clk(clk), .rst(rst), .load(go), .step(step), .init('0), .cur(c_addr));

    fir_addr_gen #(.N(N), .DOWN(1'b1)) i_swalk (
        .clk(clk), .rst(rst), .load(go), .step(step), .init(newest), .cur(s_addr));

    fir_mac_acc #(.DW(DW), .ACCW(ACCW)) i_acc (
        .clk(clk), .rst(rst), .clr(go), .en(step), .mx(mx), .my(my), .acc(result));

    always_ff @(posedge clk) begin
        if (rst) begin
            mx <= '0;
            my <= '0;
        end else if (go || step) begin
            mx <= s_rd;
            my <= c_rd;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            steps_left <= '0;
            done       <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                state      <= ST_RUN;
                steps_left <= AW'(N-1);
            end else if (step) begin
                if (steps_left == '0) begin
                    state <= ST_IDLE;
                    done  <= 1'b1;
                end else begin
                    steps_left <= steps_left - 1'b1;
                end
            end
        end
    end

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R4
    go_busy_chk: assert property (@(posedge clk) disable iff (rst)
        go |=> busy);

    // R4
    finish_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R7
    ring_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(newest));

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !go) |=> $stable(result));

endmodule

// File: tb/test_fir_mac_engine.sv
`timescale 1ns/1ps
module test_fir_mac_engine;
    localparam int N    = 8;
    localparam int DW   = 16;
    localparam int AW   = 3;
    localparam int ACCW = 2*DW + AW;
    localparam int NV   = 12;
    localparam logic signed [DW-1:0] SAMP_TAB [NV] = '{
        16'sd10, -16'sd7, 16'sd300, 16'sd1, 16'sd0, -16'sd1000,
        16'sd42, 16'sd5, -16'sd3, 16'sd2000, 16'sd17, -16'sd256};

    logic clk = 1'b0, rst = 1'b1;
    logic coef_we = 1'b0, samp_valid = 1'b0, start = 1'b0;
    logic [AW-1:0] coef_addr = '0;
    logic signed [DW-1:0] coef_data = '0, samp_data = '0;
    logic samp_ready, busy, done;
    logic signed [ACCW-1:0] result;

    int tests = 0, fails = 0;
    longint hist [64];
    int hcnt = 0;
    longint coefm [N];

    always #10 clk = ~clk;

    fir_mac_engine #(.N(N), .DW(DW)) i_fir_mac_engine (
        .clk(clk), .rst(rst), .coef_we(coef_we), .coef_addr(coef_addr),
        .coef_data(coef_data), .samp_valid(samp_valid), .samp_data(samp_data),
        .samp_ready(samp_ready), .start(start), .busy(busy), .done(done),
        .result(result));

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint model();
        longint s = 0;
        for (int i = 0; i < N; i++) begin
            int idx = hcnt - 1 - i;
            if (idx >= 0) s += coefm[i] * hist[idx];
        end
        return s;
    endfunction

    task automatic push(input logic signed [DW-1:0] v);
        @(negedge clk);
        samp_valid = 1'b1; samp_data = v;
        @(negedge clk);
        samp_valid = 1'b0;
        hist[hcnt] = longint'(v); hcnt++;
    endtask

    task automatic wcoef(input int k, input logic signed [DW-1:0] v);
        @(negedge clk);
        coef_we = 1'b1; coef_addr = AW'(k); coef_data = v;
        @(negedge clk);
        coef_we = 1'b0;
        coefm[k] = longint'(v);
    endtask

    // disturb: 0 none, 1 start again (R6), 2 sample offer (R7), 3 coef write (R8)
    task automatic run_eval(input string tag, input int disturb);
        longint exp;
        exp = model();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(busy == 1'b1, {"R4 busy after start ", tag}, busy, 1);
        case (disturb)
            1: start = 1'b1;
            2: begin
                samp_valid = 1'b1; samp_data = 16'sd1234;
                check(samp_ready == 1'b0, "R7 ready low while busy", samp_ready, 0);
            end
            3: begin coef_we = 1'b1; coef_addr = '0; coef_data = 16'sd77; end
            default: ;
        endcase
        for (int k = 1; k < N; k++) begin
            @(negedge clk);
            start = 1'b0; samp_valid = 1'b0; coef_we = 1'b0;
            if (k == N-1) check(done == 1'b0, {"R4 done not early ", tag}, done, 0);
        end
        @(negedge clk);
        check(done == 1'b1 && busy == 1'b0, {"R4 done at N ", tag}, done, 1);
        check(longint'(result) == exp, {"R2 result ", tag}, longint'(result), exp);
        @(negedge clk);
        check(done == 1'b0, {"R4 R6 single done ", tag}, done, 0);
        check(longint'(result) == exp, {"R5 result holds ", tag}, longint'(result), exp);
    endtask

    initial begin
        #(20ns * 150000);
        fails++; tests++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) coefm[i] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(result == '0, "R1 result zero", longint'(result), 0);
        check(done == 1'b0 && busy == 1'b0, "R1 idle flags", {done, busy}, 0);
        check(samp_ready == 1'b1, "R1 ready high", samp_ready, 1);
        run_eval("R1 zero storage", 0);

        // R8 coefficient writes when idle
        wcoef(0, 16'sd3);  wcoef(1, -16'sd1); wcoef(2, 16'sd4);  wcoef(3, 16'sd1);
        wcoef(4, -16'sd5); wcoef(5, 16'sd9);  wcoef(6, -16'sd2); wcoef(7, 16'sd6);

        // R2 R3 table walk: window slides, wraps past N
        for (int v = 0; v < NV; v++) begin
            push(SAMP_TAB[v]);
            run_eval("R3 table", 0);
        end

        run_eval("R6 restart ignored", 1);
        run_eval("R7 blocked sample", 2);
        run_eval("R7 after blocked sample", 0);
        run_eval("R8 blocked coef", 3);
        run_eval("R8 after blocked coef", 0);

        // R7 start has priority over a sample offer
        @(negedge clk);
        start = 1'b1; samp_valid = 1'b1; samp_data = 16'sd999;
        #1 check(samp_ready == 1'b0, "R7 ready low with start", samp_ready, 0);
        @(negedge clk);
        start = 1'b0; samp_valid = 1'b0;
        repeat (N + 1) @(negedge clk);
        run_eval("R7 start-time sample dropped", 0);

        // R9 extreme negative values
        for (int i = 0; i < N; i++) wcoef(i, -16'sd32768);
        for (int i = 0; i < N; i++) push(-16'sd32768);
        run_eval("R9 min times min", 0);
        for (int i = 0; i < N; i++) push(16'sd32767);
        run_eval("R9 max times min", 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule